// File: doc/BRIEF.md
# Separate-Port Double-Rate Burst SRAM

This block is an on-chip static memory with two one-way ports that work in the same cycle. One port only writes and the other only reads. Every address holds a two-beat burst. The first half of a clock cycle carries beat 0 and the second half carries beat 1, and both are modelled here as two parallel beat buses of one cycle. Because neither port changes direction, a lookup and an update can be issued together in any cycle, and no idle gap appears between them.

A write presents an address, both beats and a per-byte-lane keep mask. Lanes that are masked keep their stored contents, so no read-modify-write is needed. A read presents an address. Both beats come back, together with a valid strobe, a fixed number of cycles later. Reads can be issued every cycle with no gaps in the output stream. A read always sees every write issued in its own cycle or in any earlier cycle. A write that has not yet reached the array, or that arrives in the same cycle as the read, is merged lane by lane into the returned data.

Top module: `sp_burst_sram`

## Requirements
- R1: A read and a write presented in the same cycle to different addresses are both accepted. The read returns the contents from before that write, and the write takes effect for later reads.
- R2: The stored word is {beat1, beat0}. Read beat 0 returns the bits written on write beat 0, and read beat 1 returns the bits written on write beat 1.
- R3: Write mask bit i (a 1 means keep) covers lane i. For i < LANES this is bits [9i+8:9i] of beat 0, and for i >= LANES it is bits [9(i-LANES)+8:9(i-LANES)] of beat 1. A kept lane retains its old value. A write with every mask bit set changes nothing.
- R4: The edge that samples rd_en high is followed by RD_LAT - 1 further edges, after which rd_valid is high and the read beats hold the data (default RD_LAT = 2). rd_valid is low in every cycle not produced this way.
- R5: Reads issued on N consecutive cycles give rd_valid high on N consecutive cycles.
- R6: A read and an unmasked write to the same address in the same cycle return the write's beats, not the old array contents.
- R7: A read issued one or more cycles after a write to the same address returns the written data. This holds both while the write is still in flight and after it has been committed.
- R8: Forwarding merges per lane. The newest colliding write supplies its unmasked lanes, an older in-flight write supplies its unmasked lanes that the newer write does not cover, and all other lanes come from the array.
- R9: While rst is high, read requests are discarded and any in-flight read is dropped. In the cycle after rst falls, rd_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset of pipeline valids |
| wr_en | input | 1 | Write request this cycle |
| wr_addr | input | ADDR_W | Write burst address |
| wr_beat0 | input | BEAT_W | First-half write beat |
| wr_beat1 | input | BEAT_W | Second-half write beat |
| wr_mask | input | 2*LANES | Per-lane keep mask, 1 = lane unchanged |
| rd_en | input | 1 | Read request this cycle |
| rd_addr | input | ADDR_W | Read burst address |
| rd_valid | output | 1 | Read beats valid strobe |
| rd_beat0 | output | BEAT_W | First-half read beat |
| rd_beat1 | output | BEAT_W | Second-half read beat |

## Verification
The memory is first filled. It is then read with isolated single reads, with one unbroken stream of back-to-back reads running alongside writes to other addresses, and with reads paired with writes to other addresses in the same cycle. Comparing these runs separates the latency and valid-strobe behaviour from the data path. Collisions are placed at distance zero, one and two cycles from the write, which separates the same-cycle forward, the forward from the in-flight capture and a plain array read. Partial and full masks are then applied, including two overlapping in-flight masked writes to one address, to expose the per-lane priority. A reset placed while a read is in flight shows that the pending result is dropped.

// File: rtl/spb_pkg.sv
`timescale 1ns/1ps
package spb_pkg;
    localparam int DEF_ADDR_W = 6;
    localparam int DEF_BEAT_W = 36;
    localparam int DEF_LANES  = 4;
    localparam int DEF_RD_LAT = 2;
endpackage

// File: rtl/spb_wr_capture.sv
`timescale 1ns/1ps
module spb_wr_capture #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 72,
    parameter int NLANE  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [NLANE-1:0]  wr_mask,
    output logic              cap_vld,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [WORD_W-1:0] cap_word,
    output logic [NLANE-1:0]  cap_mask
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] word;
        logic [NLANE-1:0]  mask;
    } cap_t;

    cap_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = wr_en;
        if (wr_en) begin
            s_d.addr = wr_addr;
            s_d.word = wr_word;
            s_d.mask = wr_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cap_vld  = s_q.vld;
    assign cap_addr = s_q.addr;
    assign cap_word = s_q.word;
    assign cap_mask = s_q.mask;
endmodule

// File: rtl/spb_lane_bank.sv
`timescale 1ns/1ps
module spb_lane_bank #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int NLANE  = 8
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [NLANE*LANE_W-1:0] wdata,
    input  logic [NLANE-1:0]        wmask,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [NLANE*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [LANE_W-1:0] cells_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we && !wmask[g]) cells_q[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = cells_q[raddr];
    end
endmodule

// File: rtl/spb_fwd_merge.sv
`timescale 1ns/1ps
module spb_fwd_merge #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int NLANE  = 8
) (
    input  logic [ADDR_W-1:0]       raddr,
    input  logic [NLANE*LANE_W-1:0] base_word,
    input  logic                    old_vld,
    input  logic [ADDR_W-1:0]       old_addr,
    input  logic [NLANE*LANE_W-1:0] old_word,
    input  logic [NLANE-1:0]        old_mask,
    input  logic                    new_vld,
    input  logic [ADDR_W-1:0]       new_addr,
    input  logic [NLANE*LANE_W-1:0] new_word,
    input  logic [NLANE-1:0]        new_mask,
    output logic [NLANE*LANE_W-1:0] merged_word
);
    logic old_hit, new_hit;

    always_comb begin
        old_hit = old_vld && (old_addr == raddr);
        new_hit = new_vld && (new_addr == raddr);
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        always_comb begin
            if (new_hit && !new_mask[g])
                merged_word[g*LANE_W +: LANE_W] = new_word[g*LANE_W +: LANE_W];
            else if (old_hit && !old_mask[g])
                merged_word[g*LANE_W +: LANE_W] = old_word[g*LANE_W +: LANE_W];
            else
                merged_word[g*LANE_W +: LANE_W] = base_word[g*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/spb_rd_pipe.sv
`timescale 1ns/1ps
module spb_rd_pipe #(
    parameter int WORD_W = 72,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_vld,
    output logic [WORD_W-1:0] out_word,
    output logic [WORD_W-1:0] first_word
);
    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
    } stg_t;

    stg_t [RD_LAT-1:0] p_d, p_q;

    always_comb begin
        p_d[0].vld  = in_vld;
        p_d[0].word = in_word;
        for (int k = 1; k < RD_LAT; k++) p_d[k] = p_q[k-1];
    end

    always_ff @(posedge clk) begin
        p_q <= p_d;
        if (rst) begin
            for (int k = 0; k < RD_LAT; k++) p_q[k].vld <= 1'b0;
        end
    end

    assign out_vld    = p_q[RD_LAT-1].vld;
    assign out_word   = p_q[RD_LAT-1].word;
    assign first_word = p_q[0].word;
endmodule

// File: rtl/sp_burst_sram.sv
`timescale 1ns/1ps
module sp_burst_sram #(
    parameter int ADDR_W = spb_pkg::DEF_ADDR_W,
    parameter int BEAT_W = spb_pkg::DEF_BEAT_W,
    parameter int LANES  = spb_pkg::DEF_LANES,
    parameter int RD_LAT = spb_pkg::DEF_RD_LAT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BEAT_W-1:0]    wr_beat0,
    input  logic [BEAT_W-1:0]    wr_beat1,
    input  logic [2*LANES-1:0]   wr_mask,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic                 rd_valid,
    output logic [BEAT_W-1:0]    rd_beat0,
    output logic [BEAT_W-1:0]    rd_beat1
);
    localparam int LANE_W = BEAT_W / LANES;
    localparam int NLANE  = 2 * LANES;
    localparam int WORD_W = 2 * BEAT_W;

    logic [WORD_W-1:0] wr_word;
    logic              cap_vld;
    logic [ADDR_W-1:0] cap_addr;
    logic [WORD_W-1:0] cap_word;
    logic [NLANE-1:0]  cap_mask;
    logic [WORD_W-1:0] array_word;
    logic [WORD_W-1:0] merged_word;
    logic [WORD_W-1:0] out_word;
    logic [WORD_W-1:0] s1_word;

    assign wr_word = {wr_beat1, wr_beat0};

    spb_wr_capture #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NLANE(NLANE)) cap_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_word  (wr_word),
        .wr_mask  (wr_mask),
        .cap_vld  (cap_vld),
        .cap_addr (cap_addr),
        .cap_word (cap_word),
        .cap_mask (cap_mask)
    );

    spb_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .NLANE(NLANE)) bank_i (
        .clk   (clk),
        .we    (cap_vld),
        .waddr (cap_addr),
        .wdata (cap_word),
        .wmask (cap_mask),
        .raddr (rd_addr),
        .rdata (array_word)
    );

    spb_fwd_merge #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .NLANE(NLANE)) fwd_i (
        .raddr       (rd_addr),
        .base_word   (array_word),
        .old_vld     (cap_vld),
        .old_addr    (cap_addr),
        .old_word    (cap_word),
        .old_mask    (cap_mask),
        .new_vld     (wr_en),
        .new_addr    (wr_addr),
        .new_word    (wr_word),
        .new_mask    (wr_mask),
        .merged_word (merged_word)
    );

    spb_rd_pipe #(.WORD_W(WORD_W), .RD_LAT(RD_LAT)) pipe_i (
        .clk        (clk),
        .rst        (rst),
        .in_vld     (rd_en),
        .in_word    (merged_word),
        .out_vld    (rd_valid),
        .out_word   (out_word),
        .first_word (s1_word)
    );

    assign rd_beat0 = out_word[BEAT_W-1:0];
    assign rd_beat1 = out_word[WORD_W-1:BEAT_W];
endmodule

// File: rtl/spb_checker.sv
`timescale 1ns/1ps
module spb_checker #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 72,
    parameter int NLANE  = 8,
    parameter int RD_LAT = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_word,
    input logic [NLANE-1:0]  wr_mask,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic              cap_vld,
    input logic [ADDR_W-1:0] cap_addr,
    input logic [WORD_W-1:0] s1_word
);
    logic [RD_LAT-1:0] req_sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_sh_q <= '0;
        end else begin
            req_sh_q[0] <= rd_en;
            for (int k = 1; k < RD_LAT; k++) req_sh_q[k] <= req_sh_q[k-1];
        end
    end

    p_valid_latency_r4: assert property (@(posedge clk) disable iff (rst)
        rd_valid == req_sh_q[RD_LAT-1]);

    p_quiet_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rd_valid);

    p_write_capture_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cap_vld && cap_addr == $past(wr_addr)));

    p_same_cycle_fwd_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en && rd_addr == wr_addr && wr_mask == '0) |=> (s1_word == $past(wr_word)));
endmodule

bind sp_burst_sram spb_checker #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .NLANE(NLANE), .RD_LAT(RD_LAT)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_word  (wr_word),
    .wr_mask  (wr_mask),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .cap_vld  (cap_vld),
    .cap_addr (cap_addr),
    .s1_word  (s1_word)
);

// File: tb/sp_burst_sram_tb_top.sv
`timescale 1ns/1ps
module sp_burst_sram_tb_top;
    localparam int AW  = 6;
    localparam int BW  = 36;
    localparam int LN  = 4;
    localparam int LAT = 2;
    localparam int NL  = 2 * LN;
    localparam int WW  = 2 * BW;
    localparam int LW  = BW / LN;
    localparam int PER = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [BW-1:0] wr_beat0 = '0;
    logic [BW-1:0] wr_beat1 = '0;
    logic [NL-1:0] wr_mask = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_valid;
    logic [BW-1:0] rd_beat0;
    logic [BW-1:0] rd_beat1;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [WW-1:0] model [1 << AW];
    logic [WW-1:0] exp_q [$];
    time           tim_q [$];
    string         tag_q [$];
    int            run_len = 0;
    int            run_max = 0;

    always #(PER/2) clk = ~clk;

    sp_burst_sram #(.ADDR_W(AW), .BEAT_W(BW), .LANES(LN), .RD_LAT(LAT)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_beat0(wr_beat0), .wr_beat1(wr_beat1), .wr_mask(wr_mask),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_beat0(rd_beat0), .rd_beat1(rd_beat1)
    );

    // Output monitor: compares each valid beat pair against the queued expectation.
    always @(negedge clk) begin
        if (rd_valid) begin
            run_len++;
            if (run_len > run_max) run_max = run_len;
        end else begin
            run_len = 0;
        end
        if (!rst && !done) begin
            if (rd_valid) begin
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R4 unexpected rd_valid got=1 exp=0 at %0t", $time);
                end else begin
                    if ($time != tim_q[0]) begin
                        bad++;
                        $display("FAIL R4 valid time got=%0t exp=%0t", $time, tim_q[0]);
                    end
                    total++;
                    if ({rd_beat1, rd_beat0} !== exp_q[0]) begin
                        bad++;
                        $display("FAIL %s data got=%h exp=%h", tag_q[0], {rd_beat1, rd_beat0}, exp_q[0]);
                    end
                    void'(exp_q.pop_front());
                    void'(tim_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end else if (exp_q.size() > 0 && $time > tim_q[0]) begin
                total++;
                bad++;
                $display("FAIL R4 missing rd_valid got=0 exp=1 due %0t (%s)", tim_q[0], tag_q[0]);
                void'(exp_q.pop_front());
                void'(tim_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    task automatic check(input string tag, input logic [WW-1:0] got, input logic [WW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic op(input logic we, input logic [AW-1:0] wa, input logic [BW-1:0] b0,
                      input logic [BW-1:0] b1, input logic [NL-1:0] m,
                      input logic re, input logic [AW-1:0] ra, input string tag);
        logic [WW-1:0] w;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_beat0 = b0; wr_beat1 = b1; wr_mask = m;
        rd_en = re; rd_addr = ra;
        w = {b1, b0};
        if (we) begin
            for (int l = 0; l < NL; l++)
                if (!m[l]) model[wa][l*LW +: LW] = w[l*LW +: LW];
        end
        if (re) begin
            exp_q.push_back(model[ra]);
            tim_q.push_back($time + LAT * PER);
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic drain(input string tag);
        repeat (LAT + 2) @(negedge clk);
        check({tag, " drain"}, WW'(exp_q.size()), '0);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        op(1'b0, '0, '0, '0, '0, 1'b1, a, tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [BW-1:0] b0, input logic [BW-1:0] b1,
                      input logic [NL-1:0] m);
        op(1'b1, a, b0, b1, m, 1'b0, '0, "none");
    endtask

    task automatic t_reset();
        rst = 1'b1; rd_en = 1'b1; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0; rd_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check("R9 reset quiet", WW'(rd_valid), '0);
            @(negedge clk);
        end
    endtask

    task automatic t_fill();
        for (int a = 0; a < (1 << AW); a++)
            wr(AW'(a), BW'(a * 36'h1_0203 + 36'h00A), BW'(a * 36'h3_0507 + 36'h5C1), '0);
        idle();
    endtask

    task automatic t_basic();
        rd(6'd3, "R2 beat order");
        idle();
        rd(6'd40, "R4 single read");
        rd(6'd41, "R4 single read");
        idle();
        drain("R4");
    endtask

    task automatic t_stream();
        run_max = 0;
        for (int i = 0; i < 16; i++)
            op(1'b1, AW'(48 + i), BW'(i * 7 + 1), BW'(i * 11 + 2), '0, 1'b1, AW'(i), "R5 stream");
        idle();
        drain("R5");
        check("R5 consecutive valids", WW'(run_max), WW'(16));
    endtask

    task automatic t_simul();
        op(1'b1, 6'd5, 36'hA_AAAA_AAAA, 36'h5_5555_5555, '0, 1'b1, 6'd9, "R1 simultaneous other addr");
        idle();
        idle();
        rd(6'd5, "R1 write landed");
        idle();
        drain("R1");
    endtask

    task automatic t_fwd_same();
        op(1'b1, 6'd12, 36'h1_2345_6789, 36'hF_EDCB_A987, '0, 1'b1, 6'd12, "R6 same cycle");
        idle();
        drain("R6");
    endtask

    task automatic t_inflight();
        wr(6'd14, 36'h0_DEAD_BEEF, 36'h0_CAFE_F00D, '0);
        rd(6'd14, "R7 one cycle after");
        wr(6'd15, 36'h7_1111_2222, 36'h7_3333_4444, '0);
        idle();
        rd(6'd15, "R7 two cycles after");
        idle();
        drain("R7");
    endtask

    task automatic t_mask();
        wr(6'd20, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 8'b1010_0101);
        idle();
        idle();
        rd(6'd20, "R3 partial mask");
        wr(6'd21, 36'h0_0000_0000, 36'h0_0000_0000, 8'hFF);
        idle();
        idle();
        rd(6'd21, "R3 all masked no change");
        idle();
        drain("R3");
    endtask

    task automatic t_fwd_mask();
        op(1'b1, 6'd30, 36'hB_BBBB_BBBB, 36'hC_CCCC_CCCC, 8'b0011_1100, 1'b1, 6'd30, "R8 same cycle masked");
        wr(6'd31, 36'h1_1111_1111, 36'h2_2222_2222, 8'h0F);
        op(1'b1, 6'd31, 36'h3_3333_3333, 36'h4_4444_4444, 8'hF0, 1'b1, 6'd31, "R8 two-level merge");
        idle();
        rd(6'd31, "R8 after commit");
        idle();
        drain("R8");
    endtask

    task automatic t_reset_mid();
        rd(6'd2, "R9 dropped");
        void'(exp_q.pop_back());
        void'(tim_q.pop_back());
        void'(tag_q.pop_back());
        @(negedge clk);
        rd_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check("R9 in-flight dropped", WW'(rd_valid), '0);
            @(negedge clk);
        end
        rd(6'd2, "R9 read after reset");
        idle();
        drain("R9");
    endtask

    initial begin
        t_reset();
        t_fill();
        t_basic();
        t_stream();
        t_simul();
        t_fwd_same();
        t_inflight();
        t_mask();
        t_fwd_mask();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(100000 * PER);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule